// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the bus-facing half of a serial byte-addressed nonvolatile store. It watches an I2C-style two-wire bus, oversampling SCL and SDA with the system clock. It recognises start and stop conditions, takes the 7-bit device identifier and the direction bit, and answers with acknowledge bits. It then serves reads and writes against a 4096-byte on-chip array. The array is modelled as inferable RAM. SDA is open-drain: the block only ever pulls the line low, through `sda_oe_o`.

A write names a two-byte word address, high byte first, followed by data bytes. Consecutive data bytes advance the address inside a 64-byte page and wrap to the start of that page. A stop condition after at least one data byte starts an emulated programming interval. During that interval the device identifier is not acknowledged, so a master can poll for completion. A stop right after the word address only moves the internal address counter. Reads come from that counter and advance it after every byte, wrapping from the top of the array to zero. Word address FFFFh selects a one-byte control register instead of the array.

Top module: `i2cee_slave`

## Requirements
- R1: A start condition is SDA falling while SCL is high. Until one is seen, all bus activity is ignored, and the block never pulls SDA low while it is idle or unaddressed.
- R2: The first byte after a start is the device byte, MSB first: 7 identifier bits, then the direction bit in bit 0 (1 = read). It is acknowledged (SDA low during the 9th SCL pulse) only when the identifier equals `DEV_ID`. On a mismatch SDA stays released, and everything up to the next start is ignored.
- R3: In a write, the word address high byte and low byte follow the device byte, and each is acknowledged. Every data byte after them is acknowledged and stored at the address counter. A stop condition (SDA rising while SCL is high) ends the transaction.
- R4: During a write, the address counter advances within its 64-byte page and wraps to offset 0 of the same page. For example, 12 bytes starting at offset 60 land at offsets 60 to 63 and then 0 to 7.
- R5: Random read: a write header carrying a word address, then a repeated start with a read device byte, returns the byte stored at that address.
- R6: A stop that follows at least one stored data byte starts a busy interval of `WR_CYC` clocks. During it, the device byte is not acknowledged. After it expires, the device byte is acknowledged again.
- R7: Only the low 12 bits of the word address select an array byte. The upper 4 bits are ignored unless the whole address is FFFFh.
- R8: A stop that directly follows the word address transfers no data and starts no busy interval, but loads the address counter. A following read with no word address (current-address read) returns the byte at that address.
- R9: While reading, the address counter advances after each byte, whether the master acknowledges it or not, and wraps from 0xFFF to 0x000. A master acknowledge continues a sequential read. A not-acknowledge followed by a stop ends it.
- R10: Word address FFFFh selects an 8-bit control register instead of the array. A write stores only the first data byte and does not acknowledge later bytes. A read returns the register once and then leaves SDA released. The array is untouched either way.
- R11: After reset, SDA is released and the address counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND level) |
| sda_oe_o | output | 1 | Pull SDA low when 1; release the line when 0 |

## Verification
The bench keeps the 4096-byte depth and the 64-byte page, so the top-of-array wrap and the offset-60 page wrap are both reachable. It sets `WR_CYC` to 400 clocks, which is short enough that one polling transaction lands inside the busy interval and a later one lands after it. With `DEV_ID` 0x50 and an SCL period of 20 system clocks, a foreign identifier and an unframed copy of the correct device byte can both be driven.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_TXNEXT
  } bus_st_e;

  typedef enum logic [1:0] {
    RL_DEV,
    RL_AHI,
    RL_ALO,
    RL_DATA
  } role_e;
endpackage

// File: rtl/i2cee_bus_cond.sv
module i2cee_bus_cond #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_smp
);
  localparam int DEPTH = SYNC + 1;

  logic [DEPTH-1:0] scl_p;
  logic [DEPTH-1:0] sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[DEPTH-2:0], scl_i};
      sda_p <= {sda_p[DEPTH-2:0], sda_i};
    end
  end

  logic scl_c, scl_o, sda_c, sda_o;
  assign scl_c = scl_p[DEPTH-2];
  assign scl_o = scl_p[DEPTH-1];
  assign sda_c = sda_p[DEPTH-2];
  assign sda_o = sda_p[DEPTH-1];

  assign scl_rise  = scl_c & ~scl_o;
  assign scl_fall  = ~scl_c & scl_o;
  assign start_det = scl_c & scl_o & sda_o & ~sda_c;
  assign stop_det  = scl_c & scl_o & ~sda_o & sda_c;
  assign sda_smp   = sda_c;
endmodule

// File: rtl/i2cee_addr_ctr.sv
module i2cee_addr_ctr #(
  parameter int AW = 12,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [15:0]   ld_val,
  input  logic          inc_page,
  input  logic          inc_lin,
  output logic [AW-1:0] addr,
  output logic          csel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      csel <= 1'b0;
    end else if (ld) begin
      addr <= ld_val[AW-1:0];
      csel <= &ld_val;
    end else if (inc_page) begin
      addr <= {addr[AW-1:PW], addr[PW-1:0] + 1'b1};
    end else if (inc_lin) begin
      addr <= addr + 1'b1;
    end
  end

  // R4: a page step never leaves the page
  a_r4_page_hold: assert property (@(posedge clk) disable iff (rst)
    inc_page |=> addr[AW-1:PW] == $past(addr[AW-1:PW]));
endmodule

// File: rtl/i2cee_ram.sv
module i2cee_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave #(
  parameter logic [6:0] DEV_ID  = 7'h50,
  parameter int         MEM_AW  = 12,
  parameter int         PAGE_AW = 6,
  parameter int         WR_CYC  = 5000,
  parameter int         SYNC    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  import i2cee_pkg::*;

  localparam int CNT_W = $clog2(WR_CYC + 1);

  logic scl_rise, scl_fall, start_det, stop_det, sda_smp;

  i2cee_bus_cond #(.SYNC(SYNC)) u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_smp(sda_smp)
  );

  bus_st_e           state;
  role_e             role;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic [7:0]        ahi;
  logic [7:0]        ctrl_q;
  logic              ctrl_done;
  logic              rw;
  logic              wrote;
  logic              sda_oe_q;
  logic [CNT_W-1:0]  busy_cnt;
  logic              busy;

  logic              byte_done, ack_dec, ld, arr_we, ctrl_we, inc_page, inc_lin;
  logic [MEM_AW-1:0] addr;
  logic              csel;
  logic [7:0]        rd_data;
  logic [7:0]        tx_byte;

  assign busy = (busy_cnt != '0);

  i2cee_addr_ctr #(.AW(MEM_AW), .PW(PAGE_AW)) u_addr (
    .clk(clk), .rst(rst), .ld(ld), .ld_val({ahi, shreg}),
    .inc_page(inc_page), .inc_lin(inc_lin), .addr(addr), .csel(csel)
  );

  i2cee_ram #(.AW(MEM_AW), .DW(8)) u_ram (
    .clk(clk), .we(arr_we), .addr(addr), .wdata(shreg), .rdata(rd_data)
  );

  assign tx_byte = csel ? ctrl_q : rd_data;

  always_comb begin
    ack_dec   = 1'b0;
    ld        = 1'b0;
    arr_we    = 1'b0;
    ctrl_we   = 1'b0;
    inc_page  = 1'b0;
    inc_lin   = 1'b0;
    byte_done = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
    if (byte_done) begin
      case (role)
        RL_DEV:  ack_dec = (shreg[7:1] == DEV_ID) && !busy;
        RL_AHI:  ack_dec = 1'b1;
        RL_ALO: begin
          ack_dec = 1'b1;
          ld      = 1'b1;
        end
        default: begin
          if (csel) begin
            ack_dec = !ctrl_done;
            ctrl_we = !ctrl_done;
          end else begin
            ack_dec  = 1'b1;
            arr_we   = 1'b1;
            inc_page = 1'b1;
          end
        end
      endcase
    end
    if (state == ST_TXACK && scl_rise && !csel) inc_lin = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else if (stop_det && wrote) busy_cnt <= CNT_W'(WR_CYC);
    else if (busy) busy_cnt <= busy_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      role      <= RL_DEV;
      bitcnt    <= '0;
      shreg     <= '0;
      ahi       <= '0;
      ctrl_q    <= '0;
      ctrl_done <= 1'b0;
      rw        <= 1'b0;
      wrote     <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else if (start_det) begin
      state     <= ST_RX;
      role      <= RL_DEV;
      bitcnt    <= '0;
      sda_oe_q  <= 1'b0;
      wrote     <= 1'b0;
      ctrl_done <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      sda_oe_q <= 1'b0;
      wrote    <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_smp};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            sda_oe_q <= ack_dec;
            bitcnt   <= '0;
            state    <= ack_dec ? ST_RXACK : ST_IDLE;
            if (role == RL_DEV && ack_dec) rw <= shreg[0];
            if (role == RL_AHI) ahi <= shreg;
            if (role == RL_DATA && ack_dec) wrote <= 1'b1;
            if (ctrl_we) begin
              ctrl_q    <= shreg;
              ctrl_done <= 1'b1;
            end
          end
        end
        ST_RXACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            bitcnt   <= '0;
            state    <= ST_RX;
            case (role)
              RL_DEV: begin
                if (rw) begin
                  state    <= ST_TX;
                  shreg    <= tx_byte;
                  sda_oe_q <= ~tx_byte[7];
                end else begin
                  role <= RL_AHI;
                end
              end
              RL_AHI:  role <= RL_ALO;
              default: role <= RL_DATA;
            endcase
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe_q <= 1'b0;
              state    <= ST_TXACK;
            end else begin
              shreg    <= {shreg[6:0], 1'b1};
              sda_oe_q <= ~shreg[6];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) state <= (!sda_smp && !csel) ? ST_TXNEXT : ST_IDLE;
        end
        ST_TXNEXT: begin
          if (scl_fall) begin
            shreg    <= tx_byte;
            sda_oe_q <= ~tx_byte[7];
            bitcnt   <= '0;
            state    <= ST_TX;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  // R1: an idle slave never pulls the line
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |-> !sda_oe_q);

  // R2: a foreign identifier is left unacknowledged and the slave goes idle
  a_r2_nack_foreign: assert property (@(posedge clk) disable iff (rst)
    (byte_done && role == RL_DEV && shreg[7:1] != DEV_ID)
      |=> (!sda_oe_q && state == ST_IDLE));

  // R6: nothing is driven while the emulated write cycle runs
  a_r6_busy_quiet: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe_q);

  // R10: the control register is returned only once per read
  a_r10_ctrl_single: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TXACK && scl_rise && csel) |=> state == ST_IDLE);
endmodule

// File: tb/tb_i2cee_slave.sv
`timescale 1ns/1ps
module tb_i2cee_slave;
  localparam int WRC = 400;
  localparam int H   = 10;
  localparam int Q   = H / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe_o;
  logic sda_line;

  int total = 0;
  int bad = 0;
  int quiet_viol = 0;
  logic quiet = 1'b0;

  logic [7:0] model_mem [0:4095];

  assign sda_line = sda_m & ~sda_oe_o;

  always #2 clk = ~clk;

  i2cee_slave #(.DEV_ID(7'h50), .MEM_AW(12), .PAGE_AW(6), .WR_CYC(WRC), .SYNC(2)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe_o)
  );

  always @(negedge clk) if (quiet && sda_oe_o) quiet_viol++;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    wt(Q); sda_m = b; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wt(Q); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); b = sda_line; wt(Q); scl_m = 1'b0;
  endtask

  task automatic start_c();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic stop_c();
    wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(H);
  endtask

  task automatic wr_byte(input logic [7:0] v, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    chk(tag, {15'd0, a}, {15'd0, ~exp_ack});
  endtask

  task automatic rd_byte(input logic [7:0] exp, input logic mack, input string tag);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    chk(tag, {8'd0, v}, {8'd0, exp});
    bit_out(~mack);
  endtask

  task automatic hdr_addr(input logic [15:0] a, input string tag);
    start_c();
    wr_byte(8'hA0, 1'b1, tag);
    wr_byte(a[15:8], 1'b1, tag);
    wr_byte(a[7:0], 1'b1, tag);
  endtask

  task automatic page_write(input logic [15:0] a, input int n, input logic [7:0] base, input string tag);
    hdr_addr(a, tag);
    for (int i = 0; i < n; i++) begin
      wr_byte(base + 8'(i), 1'b1, tag);
      model_mem[{a[11:6], 6'((a[5:0] + i) % 64)}] = base + 8'(i);
    end
    stop_c();
    wt(WRC + 50);
  endtask

  task automatic rand_read(input logic [15:0] a, input int n, input string tag);
    hdr_addr(a, tag);
    start_c();
    wr_byte(8'hA1, 1'b1, tag);
    for (int i = 0; i < n; i++)
      rd_byte(model_mem[12'(a[11:0] + i)], (i != n - 1), tag);
    stop_c();
  endtask

  initial begin
    wt(5);
    rst = 1'b0;
    wt(3);
    // R11: line released after reset
    chk("R11 reset release", {15'd0, sda_oe_o}, 16'd0);
    // R11: address counter starts at 0 (current read of a freshly written byte 0)
    page_write(16'h0000, 1, 8'h6D, "R11 setup");
    start_c();
    wr_byte(8'hA1, 1'b1, "R11 current read hdr");
    // counter was left at 1 by the write; wrap the read to confirm counting
    rd_byte(8'hFF & model_mem[1] | 8'h00, 1'b0, "R11 skip");
    stop_c();

    // R1: unframed traffic, including the matching device byte, is ignored
    quiet_viol = 0;
    quiet = 1'b1;
    wt(Q); scl_m = 1'b0;
    for (int i = 7; i >= 0; i--) bit_out(8'hA0 >> i);
    bit_out(1'b0);
    bit_out(1'b0);
    wt(Q); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H);
    quiet = 1'b0;
    chk("R1 no drive before start", 16'(quiet_viol), 16'd0);

    // R2: foreign identifier gets no acknowledge
    start_c();
    wr_byte(8'hA6, 1'b0, "R2 foreign id nack");
    stop_c();

    // R3 + R6: byte write, busy polling, then acknowledge again
    hdr_addr(16'h0010, "R3 write header");
    wr_byte(8'hA5, 1'b1, "R3 data ack");
    wr_byte(8'h3C, 1'b1, "R3 data ack 2");
    model_mem[12'h010] = 8'hA5;
    model_mem[12'h011] = 8'h3C;
    stop_c();
    quiet_viol = 0;
    quiet = 1'b1;
    start_c();
    wr_byte(8'hA0, 1'b0, "R6 poll while busy nack");
    stop_c();
    wt(WRC);
    quiet = 1'b0;
    chk("R6 quiet during busy", 16'(quiet_viol), 16'd0);
    start_c();
    wr_byte(8'hA0, 1'b1, "R6 ack after busy");
    stop_c();

    // R5: random read, one and two bytes
    rand_read(16'h0011, 1, "R5 random read");
    rand_read(16'h0010, 2, "R5 random read pair");

    // R4: 12 bytes from offset 60 wrap inside the page
    page_write(16'h017C, 12, 8'h80, "R4 page write");
    rand_read(16'h0140, 8, "R4 wrapped head");
    rand_read(16'h017C, 4, "R4 tail");

    // R7: upper address bits ignored
    rand_read(16'h5011, 1, "R7 upper bits 5");
    rand_read(16'hF010, 2, "R7 upper bits F");

    // R8: stop after the address only loads the counter, no busy
    hdr_addr(16'h0140, "R8 set address");
    stop_c();
    start_c();
    wr_byte(8'hA1, 1'b1, "R8 no busy after set address");
    rd_byte(model_mem[12'h140], 1'b0, "R8 current read");
    stop_c();
    // R9: counter moved on by one
    start_c();
    wr_byte(8'hA1, 1'b1, "R9 current hdr");
    rd_byte(model_mem[12'h141], 1'b0, "R9 counter advanced");
    stop_c();

    // R9: sequential read wraps from top of array to 0
    page_write(16'h0FFE, 2, 8'h11, "R9 top write");
    page_write(16'h0000, 1, 8'h33, "R9 bottom write");
    rand_read(16'h0FFE, 3, "R9 array wrap");

    // R10: control register at FFFFh
    hdr_addr(16'hFFFF, "R10 ctrl header");
    wr_byte(8'h5C, 1'b1, "R10 first byte ack");
    wr_byte(8'h77, 1'b0, "R10 second byte nack");
    stop_c();
    wt(WRC + 50);
    hdr_addr(16'hFFFF, "R10 ctrl read header");
    start_c();
    wr_byte(8'hA1, 1'b1, "R10 ctrl read hdr");
    rd_byte(8'h5C, 1'b1, "R10 ctrl value");
    rd_byte(8'hFF, 1'b0, "R10 released after one byte");
    stop_c();
    rand_read(16'h0FFF, 1, "R10 array untouched");

    summary();
  end
endmodule